// File: doc/BRIEF.md
# Constrained Event-to-Counter Allocator

This block hands out hardware event counters. A requester presents an 8-bit event code, and the block answers with the index of one of ten counters that may count that event. Each event code has a fixed set of permitted counters, and that set is often irregular. Some codes may only go to a single counter. Some may only go to scattered subsets. Two codes may also go to counters 0 and 1, which no other code may use.

The block keeps a ten-bit record of which counters are taken. On each accepted allocation it picks the lowest-numbered counter that is both permitted and free, and marks it taken in the same cycle. A separate release channel frees a counter by index. The response comes back over a valid/ready channel. It is registered and is held until the consumer takes it.

Top module: `counter_alloc`

## Requirements
- R1: After reset, `used_mask` is 0, `rsp_valid` is 0, `rel_err` is 0 and `alloc_ready` is 1.
- R2: An event code that has no special entry may use counters 2 to 9 only. For example, code 0x10 on an empty pool gets counter 2.
- R3: Code 0x02 may use counter 0 or any of counters 2 to 9. On an empty pool it gets counter 0, and the next request with this code gets counter 2.
- R4: Code 0x8C may use counter 1 or counter 7 and no other counter. A third request with this code fails.
- R5: Codes 0x01, 0x97, 0x9A and 0x9F may use counter 7 only.
- R6: Codes 0x8D, 0x8E, 0x8F, 0x90, 0x93 to 0x96, 0x98, 0x99, 0x9B, 0x9C, 0xBF, 0xC0, 0xC1, 0xC4, 0xC5, 0xC6, 0xC8, 0xCA and 0xCB may use counters 5, 6 and 7 only.
- R7: Codes 0xF5, 0xF6, 0xF7 and 0xFD may use counters 2, 4 and 6 only. Code 0xF8 may use counters 2 to 7.
- R8: A granted allocation returns the lowest permitted free index, with `rsp_ok`=1. Bit i of `used_mask` (counter i) is then set.
- R9: When no permitted counter is free, the response has `rsp_ok`=0 and `used_mask` does not change.
- R10: A release of a used index below 10 clears that bit of `used_mask` at the next clock edge.
- R11: The response appears in the cycle after the request is accepted. While `rsp_valid`=1 and `rsp_ready`=0, the response is held stable and `alloc_ready` is 0.
- R12: When a release and an allocation are accepted in the same cycle, the release is applied first, so the allocation may take the counter just freed.
- R13: A release of an index that is not in use, or of an index of 10 or above, leaves `used_mask` unchanged and sets `rel_err`. `rel_err` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request present |
| alloc_ready | output | 1 | Allocation request can be accepted |
| alloc_code | input | 8 | Event code to place |
| rel_valid | input | 1 | Release request present |
| rel_ready | output | 1 | Release can be accepted (always 1) |
| rel_idx | input | 4 | Counter index to free |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_ok | output | 1 | 1 = granted, 0 = no permitted counter free |
| rsp_idx | output | 4 | Granted counter index (0 on failure) |
| used_mask | output | 10 | Bit i set = counter i is taken |
| rel_err | output | 1 | Sticky flag for an invalid release |

## Verification
The bench fills the restricted subsets until they are exhausted. A design that used a generic free-slot search would grant counters outside the permitted set, or fail to report failure. Failure cases are checked for an unchanged mask, to catch a design that marks a bit even when nothing was granted. A release issued in the same cycle as an allocation aimed at that single counter is the test for release-first ordering; a design that ordered them the other way would report failure. Invalid and out-of-range releases are checked for a mask that is left alone and a flag that stays set. A stalled consumer is used to expose responses that change or requests that slip through while the response is held.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
    localparam int NUM_CTR = 10;
    localparam int CODE_W  = 8;
    localparam int IDX_W   = $clog2(NUM_CTR);

    typedef logic [NUM_CTR-1:0] ctr_mask_t;

    // Permitted counters for each event code.
    function automatic ctr_mask_t code_affinity(input logic [CODE_W-1:0] code);
        ctr_mask_t m;
        case (code)
            8'h02:                                 m = 10'b11_1111_1101;
            8'h8C:                                 m = 10'b00_1000_0010;
            8'h01, 8'h97, 8'h9A, 8'h9F:            m = 10'b00_1000_0000;
            8'h8D, 8'h8E, 8'h8F, 8'h90,
            8'h93, 8'h94, 8'h95, 8'h96,
            8'h98, 8'h99, 8'h9B, 8'h9C,
            8'hBF, 8'hC0, 8'hC1, 8'hC4,
            8'hC5, 8'hC6, 8'hC8, 8'hCA, 8'hCB:     m = 10'b00_1110_0000;
            8'hF5, 8'hF6, 8'hF7, 8'hFD:            m = 10'b00_0101_0100;
            8'hF8:                                 m = 10'b00_1111_1100;
            default:                               m = 10'b11_1111_1100;
        endcase
        return m;
    endfunction

    typedef struct packed {
        ctr_mask_t        used;
        logic             rsp_valid;
        logic             rsp_ok;
        logic [IDX_W-1:0] rsp_idx;
        logic             err;
    } alloc_state_t;
endpackage

// File: rtl/affinity_lut.sv
module affinity_lut
    import alloc_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output ctr_mask_t         allowed
);
    always_comb allowed = code_affinity(code);
endmodule

// File: rtl/pick_lowest.sv
module pick_lowest #(
    parameter int N   = 10,
    parameter int IW  = $clog2(N)
) (
    input  logic [N-1:0]  cand,
    output logic          found,
    output logic [IW-1:0] idx
);
    logic [N-1:0] below;   // some lower candidate exists
    logic [N-1:0] grant;

    assign below[0] = 1'b0;
    genvar g;
    generate
        for (g = 1; g < N; g++) begin : g_chain
            assign below[g] = below[g-1] | cand[g-1];
        end
    endgenerate

    assign grant = cand & ~below;
    assign found = |cand;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++)
            if (grant[i]) idx = IW'(i);
    end

    // R8: at most one counter chosen
    always_comb a_single_grant_r8: assert ($onehot0(grant));
endmodule

// File: rtl/counter_alloc.sv
module counter_alloc
    import alloc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    output logic              alloc_ready,
    input  logic [CODE_W-1:0] alloc_code,
    input  logic              rel_valid,
    output logic              rel_ready,
    input  logic [IDX_W-1:0]  rel_idx,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_ok,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic [NUM_CTR-1:0] used_mask,
    output logic              rel_err
);
    alloc_state_t st_q, st_d;

    ctr_mask_t        aff_mask, rel_bit, used_rel, cand;
    logic             alloc_fire, rel_ok, pick_found;
    logic [IDX_W-1:0] pick_idx;

    affinity_lut u_lut (.code(alloc_code), .allowed(aff_mask));

    pick_lowest #(.N(NUM_CTR), .IW(IDX_W)) u_pick (
        .cand(cand), .found(pick_found), .idx(pick_idx)
    );

    assign rel_ready   = 1'b1;
    assign alloc_ready = !st_q.rsp_valid || rsp_ready;
    assign alloc_fire  = alloc_valid && alloc_ready;

    always_comb begin
        rel_ok   = (32'(rel_idx) < NUM_CTR) && ((st_q.used >> rel_idx) & ctr_mask_t'(1)) != '0;
        rel_bit  = (rel_valid && rel_ok) ? (ctr_mask_t'(1) << rel_idx) : '0;
        used_rel = st_q.used & ~rel_bit;        // release applied first
        cand     = aff_mask & ~used_rel;

        st_d      = st_q;
        st_d.used = used_rel;
        if (rel_valid && !rel_ok) st_d.err = 1'b1;
        if (st_q.rsp_valid && rsp_ready) st_d.rsp_valid = 1'b0;
        if (alloc_fire) begin
            st_d.rsp_valid = 1'b1;
            st_d.rsp_ok    = pick_found;
            st_d.rsp_idx   = pick_found ? pick_idx : '0;
            if (pick_found) st_d.used = used_rel | (ctr_mask_t'(1) << pick_idx);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_ok    = st_q.rsp_ok;
    assign rsp_idx   = st_q.rsp_idx;
    assign used_mask = st_q.used;
    assign rel_err   = st_q.err;

    // R8: a grant lies inside the permitted set and is then marked used
    p_grant_allowed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fire |=> (!st_q.rsp_ok ||
            ((($past(aff_mask) >> st_q.rsp_idx) & ctr_mask_t'(1)) != '0 &&
             ((st_q.used >> st_q.rsp_idx) & ctr_mask_t'(1)) != '0)));
    // R9: failed allocation without release leaves the mask alone
    p_fail_keeps_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_fire && !rel_valid) |=> (st_q.rsp_ok || st_q.used == $past(st_q.used)));
    // R11: held response stays stable
    p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rsp_valid && !rsp_ready) |=> (st_q.rsp_valid && $stable(st_q.rsp_idx) && $stable(st_q.rsp_ok)));
    // R13: error flag is sticky
    p_err_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |=> st_q.err);
    // R8: index always in range
    p_idx_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rsp_valid |-> (32'(st_q.rsp_idx) < NUM_CTR));
endmodule

// File: tb/tb_counter_alloc.sv
module tb_counter_alloc;
    logic       clk = 0, rst_n = 0;
    logic       alloc_valid = 0, rel_valid = 0, rsp_ready = 1;
    logic [7:0] alloc_code = 0;
    logic [3:0] rel_idx = 0;
    logic       alloc_ready, rel_ready, rsp_valid, rsp_ok, rel_err;
    logic [3:0] rsp_idx;
    logic [9:0] used_mask;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    counter_alloc dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_alloc(input logic [7:0] code, input bit ok, input int idx, input string tag);
        @(negedge clk); alloc_valid = 1; alloc_code = code;
        @(posedge clk); #1;
        chk({tag, " valid"}, rsp_valid, 1);
        chk({tag, " ok"}, rsp_ok, ok);
        if (ok) chk({tag, " idx"}, rsp_idx, idx);
        @(negedge clk); alloc_valid = 0;
    endtask

    task automatic do_rel(input int idx);
        @(negedge clk); rel_valid = 1; rel_idx = 4'(idx);
        @(posedge clk); #1;
        @(negedge clk); rel_valid = 0;
    endtask

    task automatic t_reset();
        chk("R1 used", used_mask, 0); chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 err", rel_err, 0);    chk("R1 ready", alloc_ready, 1);
    endtask

    task automatic t_default();
        do_alloc(8'h10, 1, 2, "R2 first");
        do_alloc(8'h33, 1, 3, "R2 second");
        do_rel(2); do_rel(3);
        chk("R10 cleared", used_mask, 0);
    endtask

    task automatic t_cycles();
        do_alloc(8'h02, 1, 0, "R3 first");
        do_alloc(8'h02, 1, 2, "R3 second");
        do_rel(0); do_rel(2);
    endtask

    task automatic t_instr();
        do_alloc(8'h8C, 1, 1, "R4 first");
        do_alloc(8'h8C, 1, 7, "R4 second");
        do_alloc(8'h8C, 0, 0, "R4 third");
        chk("R9 mask kept", used_mask, 10'h082);
        do_rel(1); do_rel(7);
    endtask

    task automatic t_single();
        do_alloc(8'h97, 1, 7, "R5 0x97");
        do_alloc(8'h01, 0, 0, "R5 0x01 busy");
        do_rel(7);
        do_alloc(8'h9F, 1, 7, "R5 0x9F");
        do_rel(7);
    endtask

    task automatic t_567();
        do_alloc(8'h93, 1, 5, "R6 0x93");
        do_alloc(8'hC8, 1, 6, "R6 0xC8");
        do_alloc(8'hCB, 1, 7, "R6 0xCB");
        do_alloc(8'h8D, 0, 0, "R6 full");
        chk("R9 mask 567", used_mask, 10'h0E0);
        do_rel(5); do_rel(6); do_rel(7);
    endtask

    task automatic t_246();
        do_alloc(8'hF5, 1, 2, "R7 0xF5");
        do_alloc(8'hFD, 1, 4, "R7 0xFD");
        do_alloc(8'hF6, 1, 6, "R7 0xF6");
        do_alloc(8'hF7, 0, 0, "R7 0xF7 full");
        do_alloc(8'hF8, 1, 3, "R7 0xF8");
        chk("R8 mask 246", used_mask, 10'h05C);
        do_rel(2); do_rel(3); do_rel(4); do_rel(6);
    endtask

    task automatic t_fill();
        for (int i = 2; i < 10; i++) do_alloc(8'h10, 1, i, "R8 fill");
        do_alloc(8'h10, 0, 0, "R9 exhausted");
        chk("R9 mask full", used_mask, 10'h3FC);
        do_alloc(8'h02, 1, 0, "R3 counter0 left");
        for (int i = 0; i < 10; i++) if (i != 1) do_rel(i);
        chk("R10 all freed", used_mask, 0);
    endtask

    task automatic t_same_cycle();
        do_alloc(8'h01, 1, 7, "R12 setup");
        @(negedge clk); alloc_valid = 1; alloc_code = 8'h9A; rel_valid = 1; rel_idx = 7;
        @(posedge clk); #1;
        chk("R12 ok", rsp_ok, 1); chk("R12 idx", rsp_idx, 7);
        chk("R12 mask", used_mask, 10'h080);
        chk("R12 no err", rel_err, 0);
        @(negedge clk); alloc_valid = 0; rel_valid = 0;
        do_rel(7);
    endtask

    task automatic t_hold();
        @(negedge clk); rsp_ready = 0; alloc_valid = 1; alloc_code = 8'h10;
        @(posedge clk); #1;
        chk("R11 valid", rsp_valid, 1); chk("R11 idx", rsp_idx, 2);
        @(negedge clk); alloc_code = 8'h11;
        repeat (3) @(posedge clk); #1;
        chk("R11 held", rsp_idx, 2); chk("R11 stall", alloc_ready, 0);
        chk("R11 no 2nd grant", used_mask, 10'h004);
        @(negedge clk); rsp_ready = 1;
        @(posedge clk); #1;
        chk("R11 next idx", rsp_idx, 3);
        @(negedge clk); alloc_valid = 0;
        @(posedge clk); #1;
        chk("R11 drained", rsp_valid, 0);
        do_rel(2); do_rel(3);
    endtask

    task automatic t_bad_release();
        do_alloc(8'h10, 1, 2, "R13 setup");
        chk("R13 err clear", rel_err, 0);
        do_rel(3);
        chk("R13 err set", rel_err, 1); chk("R13 mask kept", used_mask, 10'h004);
        do_rel(12);
        chk("R13 mask range", used_mask, 10'h004); chk("R13 sticky", rel_err, 1);
        do_rel(2);
        chk("R13 still set", rel_err, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        t_reset();
        t_default(); t_cycles(); t_instr(); t_single();
        t_567(); t_246(); t_fill(); t_same_cycle(); t_hold(); t_bad_release();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule